// File: doc/BRIEF.md
# Timed SAR ADC Conversion Sequencer

This block runs a 16-bit successive-approximation converter that has a serial data output, together with an 8-way analog input selector placed in front of it. After reset it waits through a settling phase. It then repeats a fixed frame for each sample. First it raises the convert line and holds it for the conversion time. It then opens the serial-clock gate for exactly one clock per data bit and shifts the bits in, most significant first. The finished word is presented with a one-cycle valid strobe. At the end of every conversion wait it pulses a select-advance strobe, so the selector has moved on to the next input before the next acquisition begins.

All phase lengths come from two elaboration parameters: the clock frequency and the sample rate. The settling phase lasts at least 1000 ns. The conversion phase lasts the longer of a 710 ns floor and whatever remains of the sample period after the 16 shift clocks, rounded up to whole clocks. A single up-counter times every phase. It is compared against a limit chosen by the current phase, and on a match it clears itself and advances the phase. Elaboration stops with an error in two cases: the conversion floor plus the shift clocks do not fit in one sample period, or the clock is faster than the converter's 83.33 MHz serial limit. An override input can pin the selector to a fixed input. While the override is set, the select counter stays frozen. Reset is asynchronous and active low, and it must be released synchronously to the clock.

Top module: `sar_adc_sequencer`

## Requirements
- R1: While reset is asserted, conv_o, sclk_en_o, sample_valid_o and mux_inc_o are 0, sample_o is 0, and with the override off mux_sel_o is 0.
- R2: After reset release the settling phase lasts ceil(1000 ns × CLK_HZ) cycles, which is 60 cycles at the defaults. conv_o stays low during it and rises in the cycle that follows it.
- R3: conv_o stays high for max(ceil(710 ns × CLK_HZ), ceil(CLK_HZ/SAMPLE_HZ) − 16) consecutive cycles per sample, which is 44 cycles at the defaults.
- R4: sclk_en_o is high for exactly 16 cycles, starting in the cycle after conv_o falls. It is never high together with conv_o. conv_o rises again right after it, so one frame is 60 cycles at the defaults.
- R5: mux_inc_o is a one-cycle pulse in the last cycle that conv_o is high. With the override off, the select counter then advances by one and wraps from 7 to 0. The new value shows on mux_sel_o from the first shift cycle.
- R6: sdo_i is sampled on the rising clock edge that ends each shift cycle. The first bit sampled becomes sample_o[15] and the 16th becomes sample_o[0]. sample_valid_o is high for exactly the one cycle after the last shift cycle, and sample_o holds the complete word in that cycle.
- R7: Outside the shift cycles, sdo_i has no effect. sample_o keeps the last completed word until the next shift phase.
- R8: While ovr_en_i is 1, mux_sel_o equals ovr_ch_i and the select counter ignores mux_inc_o. Once ovr_en_i returns to 0, mux_sel_o again shows the counter, which continues from the value it held. ovr_en_i is taken into account on the same edge as the advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the serial clock source once gated |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sdo_i | input | 1 | Serial data from the converter |
| ovr_en_i | input | 1 | Pins the input selector to ovr_ch_i when 1 |
| ovr_ch_i | input | 3 | Selector value used while the override is set |
| conv_o | output | 1 | Convert line, high for the whole conversion wait |
| sclk_en_o | output | 1 | Serial-clock gate, high only in shift cycles |
| sample_o | output | 16 | Last completed sample word |
| sample_valid_o | output | 1 | One-cycle strobe marking a new sample_o |
| mux_inc_o | output | 1 | One-cycle select-advance strobe at the end of the conversion wait |
| mux_sel_o | output | 3 | Input selector value |

## Verification
The select-advance strobe and a change of the override input can land on the same clock edge. The counter must then obey the override level present at that edge. The bench provokes this directly: in one frame it raises the override in exactly the advance cycle and expects the counter to stay put, and in the following frame it drops the override in the advance cycle and expects the counter to step. Outside these two cases, random override toggling and random serial data outside the shift window are judged cycle by cycle against a bench model of the frame timing and the select counter.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,
    PH_CONV  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;

  function automatic longint ceil_div(input longint num, input longint den);
    return (num + den - 1) / den;
  endfunction

  function automatic longint max_l(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == limit_i);

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i); // R4

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned BOOT_LIM  = 59,
  parameter int unsigned CONV_LIM  = 43,
  parameter int unsigned SHIFT_LIM = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             conv_o,
  output logic             sclk_en_o,
  output logic             mux_inc_o,
  output logic             shift_last_o
);

  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (tick_i) begin
      case (state_q)
        PH_BOOT:  state_d = PH_CONV;
        PH_CONV:  state_d = PH_SHIFT;
        PH_SHIFT: state_d = PH_CONV;
        default:  state_d = PH_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_BOOT;
    else         state_q <= state_d;
  end

  always_comb begin
    case (state_q)
      PH_CONV:  limit_o = CNT_W'(CONV_LIM);
      PH_SHIFT: limit_o = CNT_W'(SHIFT_LIM);
      default:  limit_o = CNT_W'(BOOT_LIM);
    endcase
  end

  assign conv_o       = (state_q == PH_CONV);
  assign sclk_en_o    = (state_q == PH_SHIFT);
  assign mux_inc_o    = conv_o & tick_i;
  assign shift_last_o = sclk_en_o & tick_i;

  AST_BOOT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PH_BOOT) |=> (state_q != PH_BOOT)); // R2
  AST_SHIFT_TO_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_last_o |=> conv_o); // R4

endmodule

// File: rtl/sar_sample_shifter.sv
module sar_sample_shifter #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                last_i,
  input  logic                sdo_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                valid_o
);

  logic [SAMPLE_W-1:0] data_q;
  logic                valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (shift_i) begin
      data_q <= {data_q[SAMPLE_W-2:0], sdo_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= last_i;
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(data_q)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R6

endmodule

// File: rtl/sar_mux_select.sv
module sar_mux_select #(
  parameter int unsigned MUX_CH = 8,
  localparam int unsigned CH_W = $clog2(MUX_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            ovr_en_i,
  input  logic [CH_W-1:0] ovr_ch_i,
  output logic [CH_W-1:0] sel_o
);

  logic [CH_W-1:0] ch_q, ch_d;
  logic            step;

  assign step = inc_i & ~ovr_en_i;

  always_comb begin
    ch_d = ch_q;
    if (step) begin
      if (ch_q == CH_W'(MUX_CH - 1)) ch_d = '0;
      else                           ch_d = ch_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_q <= '0;
    else         ch_q <= ch_d;
  end

  assign sel_o = ovr_en_i ? ovr_ch_i : ch_q;

  AST_OVR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_en_i |=> $stable(ch_q)); // R8
  AST_CH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ovr_en_i && ch_q == CH_W'(MUX_CH - 1)) |=> (ch_q == '0)); // R5

endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer
  import sar_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 60_000_000,
  parameter int unsigned SAMPLE_HZ   = 1_000_000,
  parameter int unsigned BOOT_NS     = 1000,
  parameter int unsigned CONV_MIN_NS = 710,
  parameter int unsigned SCLK_MAX_HZ = 83_333_333,
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned MUX_CH      = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sdo_i,
  input  logic                        ovr_en_i,
  input  logic [$clog2(MUX_CH)-1:0]   ovr_ch_i,
  output logic                        conv_o,
  output logic                        sclk_en_o,
  output logic [SAMPLE_W-1:0]         sample_o,
  output logic                        sample_valid_o,
  output logic                        mux_inc_o,
  output logic [$clog2(MUX_CH)-1:0]   mux_sel_o
);

  localparam longint NS_PER_S     = 64'd1_000_000_000;
  localparam longint FRAME_CYC    = ceil_div(longint'(CLK_HZ), longint'(SAMPLE_HZ));
  localparam longint BOOT_CYC     = ceil_div(longint'(BOOT_NS) * longint'(CLK_HZ), NS_PER_S);
  localparam longint CONV_MIN_CYC = ceil_div(longint'(CONV_MIN_NS) * longint'(CLK_HZ), NS_PER_S);
  localparam longint CONV_CYC     = max_l(CONV_MIN_CYC, FRAME_CYC - longint'(SAMPLE_W));
  localparam longint SHIFT_CYC    = longint'(SAMPLE_W);
  localparam longint LONGEST_CYC  = max_l(max_l(BOOT_CYC, CONV_CYC), SHIFT_CYC);
  localparam int unsigned CNT_W   = $clog2(LONGEST_CYC);
  localparam bit PARAMS_OK = (CONV_MIN_CYC + SHIFT_CYC <= FRAME_CYC) &&
                             (CLK_HZ <= SCLK_MAX_HZ) && (BOOT_CYC >= 2) &&
                             (SAMPLE_W >= 2) && (MUX_CH >= 2);

  if (!PARAMS_OK) begin : g_bad_params
    $error("sar_adc_sequencer: clock and sample rate cannot meet converter timing");
  end

  logic [CNT_W-1:0] limit;
  logic             tick;
  logic             shift_last;

  sar_phase_timer #(
    .CNT_W (CNT_W)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .limit_i (limit),
    .tick_o  (tick)
  );

  sar_seq_fsm #(
    .CNT_W     (CNT_W),
    .BOOT_LIM  (int'(BOOT_CYC - 1)),
    .CONV_LIM  (int'(CONV_CYC - 1)),
    .SHIFT_LIM (int'(SHIFT_CYC - 1))
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .limit_o      (limit),
    .conv_o       (conv_o),
    .sclk_en_o    (sclk_en_o),
    .mux_inc_o    (mux_inc_o),
    .shift_last_o (shift_last)
  );

  sar_sample_shifter #(
    .SAMPLE_W (SAMPLE_W)
  ) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sclk_en_o),
    .last_i  (shift_last),
    .sdo_i   (sdo_i),
    .data_o  (sample_o),
    .valid_o (sample_valid_o)
  );

  sar_mux_select #(
    .MUX_CH (MUX_CH)
  ) i_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (mux_inc_o),
    .ovr_en_i (ovr_en_i),
    .ovr_ch_i (ovr_ch_i),
    .sel_o    (mux_sel_o)
  );

  AST_CONV_SCLK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_o && sclk_en_o)); // R4
  AST_INC_THEN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_inc_o |=> (sclk_en_o && !conv_o)); // R5
  AST_VALID_AFTER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> (!sclk_en_o && $past(sclk_en_o))); // R6

endmodule

// File: tb/test_sar_adc_sequencer.sv
`timescale 1ns/1ps
module test_sar_adc_sequencer;

  localparam longint T_CLK  = 60_000_000;
  localparam longint T_RATE = 1_000_000;
  localparam int EXP_FRAME  = int'((T_CLK + T_RATE - 1) / T_RATE);
  localparam int EXP_BOOT   = int'((1000 * T_CLK + 999_999_999) / 1_000_000_000);
  localparam int CONV_FLOOR = int'((710 * T_CLK + 999_999_999) / 1_000_000_000);
  localparam int EXP_CONV   = (CONV_FLOOR > EXP_FRAME - 16) ? CONV_FLOOR : EXP_FRAME - 16;
  localparam int N_FRAMES   = 40;
  localparam int N_CYC      = EXP_BOOT + N_FRAMES * EXP_FRAME;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sdo_i;
  logic        ovr_en_i;
  logic [2:0]  ovr_ch_i;
  logic        conv_o, sclk_en_o, sample_valid_o, mux_inc_o;
  logic [15:0] sample_o;
  logic [2:0]  mux_sel_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  sar_adc_sequencer #(
    .CLK_HZ    (60_000_000),
    .SAMPLE_HZ (1_000_000)
  ) i_sar_adc_sequencer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sdo_i          (sdo_i),
    .ovr_en_i       (ovr_en_i),
    .ovr_ch_i       (ovr_ch_i),
    .conv_o         (conv_o),
    .sclk_en_o      (sclk_en_o),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o),
    .mux_inc_o      (mux_inc_o),
    .mux_sel_o      (mux_sel_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pick_word(input int idx);
    case (idx)
      0:       return 16'hFFFF;
      1:       return 16'h0000;
      2:       return 16'h8001;
      3:       return 16'h5AA5;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(200_000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] word_cur;
    logic [2:0]  ch_model;
    int          wraps;
    void'($urandom(32'h5EED_0042));
    word_cur = '0;
    ch_model = '0;
    wraps    = 0;
    rst_ni   = 1'b0;
    sdo_i    = 1'b1;
    ovr_en_i = 1'b0;
    ovr_ch_i = 3'd0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", "conv in reset", conv_o, 0);
    chk("R1", "sclk_en in reset", sclk_en_o, 0);
    chk("R1", "valid in reset", sample_valid_o, 0);
    chk("R1", "inc in reset", mux_inc_o, 0);
    chk("R1", "sample in reset", sample_o, 0);
    chk("R1", "sel in reset", mux_sel_o, 0);

    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < N_CYC; k++) begin
      bit exp_conv, exp_sclk, exp_inc, exp_valid;
      int u, fr;
      if (k != 0) @(negedge clk_i);
      exp_conv = 0; exp_sclk = 0; exp_inc = 0; exp_valid = 0; u = 0; fr = 0;
      if (k >= EXP_BOOT) begin
        u  = (k - EXP_BOOT) % EXP_FRAME;
        fr = (k - EXP_BOOT) / EXP_FRAME;
        exp_conv  = (u < EXP_CONV);
        exp_sclk  = (u >= EXP_CONV);
        exp_inc   = (u == EXP_CONV - 1);
        exp_valid = (u == 0) && (fr >= 1);
      end
      // serial data: real bits in shift cycles, noise elsewhere
      if (exp_sclk) begin
        if (u == EXP_CONV) word_cur = pick_word(fr);
        sdo_i = word_cur[15 - (u - EXP_CONV)];
      end else begin
        sdo_i = 1'($urandom);
      end
      // override stimulus, including two changes in the advance cycle
      if (k >= EXP_BOOT) begin
        if (fr == 5 && exp_inc) begin
          ovr_en_i = 1'b1;
          ovr_ch_i = 3'd5;
        end else if (fr == 6 && exp_inc) begin
          ovr_en_i = 1'b0;
        end else if (fr >= 10 && fr < 26) begin
          if ($urandom % 6 == 0) begin
            ovr_en_i = ~ovr_en_i;
            ovr_ch_i = 3'($urandom);
          end
        end else if (fr >= 26) begin
          ovr_en_i = 1'b0;
        end
      end
      #1;
      chk(k < EXP_BOOT + EXP_CONV ? "R2" : "R3", "conv", conv_o, exp_conv);
      chk("R4", "sclk_en", sclk_en_o, exp_sclk);
      chk("R5", "mux_inc", mux_inc_o, exp_inc);
      chk("R6", "valid", sample_valid_o, exp_valid);
      if (exp_valid) chk("R6", "sample word", sample_o, word_cur);
      if (exp_inc && fr >= 1) chk("R7", "sample held", sample_o, word_cur);
      if (ovr_en_i) chk("R8", "override sel", mux_sel_o, ovr_ch_i);
      else          chk("R5", "counter sel", mux_sel_o, ch_model);
      if (exp_inc && !ovr_en_i) begin
        if (ch_model == 3'd7) wraps++;
        ch_model = ch_model + 3'd1;
      end
    end
    chk("R5", "wrap seen", (wraps > 0), 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule